// File: doc/BRIEF.md
# Reservation Station Pool

This block is the waiting room that sits in front of one functional unit in an out-of-order core. Each issued operation takes a slot and carries its opcode, two source operands and the reorder-buffer entry that will receive its result. A source that is not yet computed is held as the reorder-buffer tag of the instruction producing it. The slot then listens to the shared result bus until that tag appears, and copies the broadcast value.

Once both sources hold values, the slot can go to the functional unit. One operation leaves per cycle. Among the ready slots, the one that was issued earliest goes first. The slot stays reserved until the functional unit's result appears on the result bus under the slot's destination tag. A misprediction flush removes every slot whose destination is younger than the branch. Age is measured as distance from the reorder-buffer head, so it stays correct when tags wrap.

Top module: `rsPool`

## Requirements
- R1: `issueAccept` is high exactly when `issueValid` is high, `robHasFree` is high, at least one slot is unoccupied and `flushValid` is low. An accepted operation takes an unoccupied slot at the next clock edge. When `issueAccept` is low, nothing is stored.
- R2: `slotFree` is high exactly when at least one slot is unoccupied. After reset all slots are unoccupied (`slotFree`=1, `dispValid`=0).
- R3: A source issued with its ready bit set keeps the supplied value. A source issued not ready keeps the supplied tag. A slot is never dispatched while either of its sources lacks a value.
- R4: When `bcastValid` is high and `bcastTag` equals the tag a waiting source holds, that source captures `bcastData` at that edge. The slot can be dispatched from the following cycle onward.
- R5: If the result bus carries the tag of a not-ready source in the same cycle that source is being issued, the source is stored with `bcastData` and counted as ready.
- R6: While `dispValid` is high, `dispOp`, `dispA`, `dispB` and `dispDest` carry the stored opcode, the two operand values and the destination tag of one slot. At most one slot dispatches per cycle, and each slot dispatches only once.
- R7: When several slots are ready, the one issued earliest is dispatched first, whatever slot positions they occupy.
- R8: A dispatched slot becomes unoccupied at the edge where the result bus carries its destination tag. A broadcast of a slot's destination tag before that slot has dispatched leaves the slot in place.
- R9: While `flushValid` is high, every occupied slot is removed when `(dest - robHead) mod 2^TAG_W` is greater than `(flushTag - robHead) mod 2^TAG_W`. Other slots remain. In that cycle `dispValid` is low and no issue is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An operation is offered for issue |
| robHasFree | input | 1 | Reorder buffer has an entry for it |
| issueOp | input | OP_W | Opcode |
| issueARdy | input | 1 | Source A holds a value |
| issueAData | input | DATA_W | Source A value |
| issueATag | input | TAG_W | Source A producer tag |
| issueBRdy | input | 1 | Source B holds a value |
| issueBData | input | DATA_W | Source B value |
| issueBTag | input | TAG_W | Source B producer tag |
| issueDest | input | TAG_W | Destination reorder-buffer entry |
| issueAccept | output | 1 | Offered operation is taken this cycle |
| slotFree | output | 1 | At least one slot is unoccupied |
| bcastValid | input | 1 | Result bus carries a result |
| bcastTag | input | TAG_W | Reorder-buffer entry of the result |
| bcastData | input | DATA_W | Result value |
| dispValid | output | 1 | An operation goes to the functional unit |
| dispOp | output | OP_W | Dispatched opcode |
| dispA | output | DATA_W | Dispatched operand A |
| dispB | output | DATA_W | Dispatched operand B |
| dispDest | output | TAG_W | Dispatched destination tag |
| flushValid | input | 1 | Misprediction flush |
| flushTag | input | TAG_W | Reorder-buffer entry of the mispredicted branch |
| robHead | input | TAG_W | Current reorder-buffer head |

## Verification
The bench fills the pool and then wakes all slots with one broadcast. Over several rotations of destination tags it checks that dispatch follows issue order and not slot index. In one case a slot that was freed early is refilled by the youngest operation; a position-priority picker would send that operation first. Other tests target the cycle a captured operand becomes usable, a broadcast that coincides with issue, and a destination-tag broadcast that arrives before dispatch. A design that loses the first wakeup would deliver a stale operand, and one that frees on the early broadcast would never dispatch the operation. Flushes are driven both with a plain head and with tags that wrap past zero. A plain unsigned compare would keep or drop the wrong slots in the wrapped case.

// File: rtl/rsPkg.sv
`timescale 1ns/1ps
package rsPkg;
  localparam int SLOT_COUNT = 4;
  localparam int SLOT_IDX_W = (SLOT_COUNT > 1) ? $clog2(SLOT_COUNT) : 1;

  typedef logic [SLOT_COUNT-1:0] slotVec_t;

  // per-slot one-hot/mask strobes from control to datapath
  typedef struct packed {
    slotVec_t issueSel;
    slotVec_t dispSel;
    slotVec_t freeSel;
    slotVec_t flushSel;
  } rsStrobes_t;
endpackage

// File: rtl/rsCtrl.sv
`timescale 1ns/1ps
module rsCtrl
  import rsPkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             issueValid,
  input  logic                             robHasFree,
  input  logic                             bcastValid,
  input  logic [TAG_W-1:0]                 bcastTag,
  input  logic                             flushValid,
  input  logic [TAG_W-1:0]                 flushTag,
  input  logic [TAG_W-1:0]                 robHead,
  input  slotVec_t                         validVec,
  input  slotVec_t                         busyVec,
  input  slotVec_t                         readyVec,
  input  logic [SLOT_COUNT-1:0][TAG_W-1:0] destTags,
  output rsStrobes_t                       strobes,
  output logic                             issueAccept,
  output logic                             slotFree
);
  logic [SLOT_COUNT-1:0][SLOT_IDX_W-1:0] age;
  logic [SLOT_COUNT-1:0][SLOT_IDX_W-1:0] ageNext;
  logic [SLOT_COUNT-1:0][TAG_W-1:0]      relDest;
  logic [TAG_W-1:0]                      relBranch;
  slotVec_t                              issuePick;
  slotVec_t                              candVec;
  slotVec_t                              keepMask;
  logic                                  found;
  logic [SLOT_IDX_W-1:0]                 bestAge;
  logic [SLOT_IDX_W-1:0]                 rank;

  assign slotFree    = ~&validVec;
  assign issueAccept = issueValid & robHasFree & slotFree & ~flushValid;
  assign candVec     = validVec & ~busyVec & readyVec;
  assign relBranch   = flushTag - robHead;

  // lowest-indexed unoccupied slot
  always_comb begin
    issuePick = '0;
    for (int i = SLOT_COUNT - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        issuePick    = '0;
        issuePick[i] = 1'b1;
      end
    end
  end

  always_comb begin
    strobes.issueSel = issueAccept ? issuePick : '0;
    strobes.dispSel  = '0;
    found   = 1'b0;
    bestAge = '0;
    for (int i = 0; i < SLOT_COUNT; i++) begin
      relDest[i]          = destTags[i] - robHead;
      strobes.flushSel[i] = flushValid & validVec[i] & (relDest[i] > relBranch);
      strobes.freeSel[i]  = validVec[i] & busyVec[i] & bcastValid & (destTags[i] == bcastTag);
      if (candVec[i] && (!found || age[i] > bestAge)) begin
        strobes.dispSel    = '0;
        strobes.dispSel[i] = 1'b1;
        found   = 1'b1;
        bestAge = age[i];
      end
    end
    if (flushValid) strobes.dispSel = '0;
  end

  // age = rank among surviving slots, shifted by one on issue
  assign keepMask = validVec & ~strobes.freeSel & ~strobes.flushSel;

  always_comb begin
    for (int i = 0; i < SLOT_COUNT; i++) begin
      rank = '0;
      for (int j = 0; j < SLOT_COUNT; j++) begin
        if (keepMask[j] && (age[j] < age[i])) rank = rank + 1'b1;
      end
      ageNext[i] = keepMask[i] ? (rank + SLOT_IDX_W'(issueAccept)) : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else       age <= ageNext;
  end
endmodule

// File: rtl/rsData.sv
`timescale 1ns/1ps
module rsData
  import rsPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3,
  parameter int OP_W   = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  rsStrobes_t                       strobes,
  input  logic [OP_W-1:0]                  issueOp,
  input  logic                             issueARdy,
  input  logic [DATA_W-1:0]                issueAData,
  input  logic [TAG_W-1:0]                 issueATag,
  input  logic                             issueBRdy,
  input  logic [DATA_W-1:0]                issueBData,
  input  logic [TAG_W-1:0]                 issueBTag,
  input  logic [TAG_W-1:0]                 issueDest,
  input  logic                             bcastValid,
  input  logic [TAG_W-1:0]                 bcastTag,
  input  logic [DATA_W-1:0]                bcastData,
  output slotVec_t                         validVec,
  output slotVec_t                         busyVec,
  output slotVec_t                         readyVec,
  output logic [SLOT_COUNT-1:0][TAG_W-1:0] destTags,
  output logic                             dispValid,
  output logic [OP_W-1:0]                  dispOp,
  output logic [DATA_W-1:0]                dispA,
  output logic [DATA_W-1:0]                dispB,
  output logic [TAG_W-1:0]                 dispDest
);
  typedef struct packed {
    logic              valid;
    logic              busy;
    logic [OP_W-1:0]   op;
    logic              rdyA;
    logic [DATA_W-1:0] valA;
    logic [TAG_W-1:0]  tagA;
    logic              rdyB;
    logic [DATA_W-1:0] valB;
    logic [TAG_W-1:0]  tagB;
    logic [TAG_W-1:0]  dest;
  } slot_t;

  slot_t slots [SLOT_COUNT];
  logic  hitIssueA, hitIssueB;

  assign hitIssueA = bcastValid & (bcastTag == issueATag);
  assign hitIssueB = bcastValid & (bcastTag == issueBTag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOT_COUNT; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < SLOT_COUNT; i++) begin
        if (strobes.flushSel[i] || strobes.freeSel[i]) begin
          slots[i].valid <= 1'b0;
          slots[i].busy  <= 1'b0;
        end else if (strobes.issueSel[i]) begin
          slots[i].valid <= 1'b1;
          slots[i].busy  <= 1'b0;
          slots[i].op    <= issueOp;
          slots[i].dest  <= issueDest;
          slots[i].tagA  <= issueATag;
          slots[i].tagB  <= issueBTag;
          slots[i].rdyA  <= issueARdy | hitIssueA;
          slots[i].valA  <= issueARdy ? issueAData : bcastData;
          slots[i].rdyB  <= issueBRdy | hitIssueB;
          slots[i].valB  <= issueBRdy ? issueBData : bcastData;
        end else if (slots[i].valid) begin
          if (strobes.dispSel[i]) slots[i].busy <= 1'b1;
          if (!slots[i].rdyA && bcastValid && slots[i].tagA == bcastTag) begin
            slots[i].rdyA <= 1'b1;
            slots[i].valA <= bcastData;
          end
          if (!slots[i].rdyB && bcastValid && slots[i].tagB == bcastTag) begin
            slots[i].rdyB <= 1'b1;
            slots[i].valB <= bcastData;
          end
        end
      end
    end
  end

  always_comb begin
    dispOp   = '0;
    dispA    = '0;
    dispB    = '0;
    dispDest = '0;
    for (int i = 0; i < SLOT_COUNT; i++) begin
      validVec[i] = slots[i].valid;
      busyVec[i]  = slots[i].busy;
      readyVec[i] = slots[i].rdyA & slots[i].rdyB;
      destTags[i] = slots[i].dest;
      if (strobes.dispSel[i]) begin
        dispOp   = dispOp   | slots[i].op;
        dispA    = dispA    | slots[i].valA;
        dispB    = dispB    | slots[i].valB;
        dispDest = dispDest | slots[i].dest;
      end
    end
  end

  assign dispValid = |strobes.dispSel;
endmodule

// File: rtl/rsPool.sv
`timescale 1ns/1ps
module rsPool
  import rsPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              robHasFree,
  input  logic [OP_W-1:0]   issueOp,
  input  logic              issueARdy,
  input  logic [DATA_W-1:0] issueAData,
  input  logic [TAG_W-1:0]  issueATag,
  input  logic              issueBRdy,
  input  logic [DATA_W-1:0] issueBData,
  input  logic [TAG_W-1:0]  issueBTag,
  input  logic [TAG_W-1:0]  issueDest,
  output logic              issueAccept,
  output logic              slotFree,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastData,
  output logic              dispValid,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispA,
  output logic [DATA_W-1:0] dispB,
  output logic [TAG_W-1:0]  dispDest,
  input  logic              flushValid,
  input  logic [TAG_W-1:0]  flushTag,
  input  logic [TAG_W-1:0]  robHead
);
  rsStrobes_t                       strobes;
  slotVec_t                         validVec, busyVec, readyVec;
  logic [SLOT_COUNT-1:0][TAG_W-1:0] destTags;

  rsCtrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .robHasFree(robHasFree),
    .bcastValid(bcastValid), .bcastTag(bcastTag),
    .flushValid(flushValid), .flushTag(flushTag), .robHead(robHead),
    .validVec(validVec), .busyVec(busyVec), .readyVec(readyVec),
    .destTags(destTags), .strobes(strobes),
    .issueAccept(issueAccept), .slotFree(slotFree)
  );

  rsData #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .issueOp(issueOp),
    .issueARdy(issueARdy), .issueAData(issueAData), .issueATag(issueATag),
    .issueBRdy(issueBRdy), .issueBData(issueBData), .issueBTag(issueBTag),
    .issueDest(issueDest),
    .bcastValid(bcastValid), .bcastTag(bcastTag), .bcastData(bcastData),
    .validVec(validVec), .busyVec(busyVec), .readyVec(readyVec),
    .destTags(destTags),
    .dispValid(dispValid), .dispOp(dispOp), .dispA(dispA), .dispB(dispB),
    .dispDest(dispDest)
  );
endmodule

// File: rtl/rsPoolChk.sv
`timescale 1ns/1ps
module rsPoolChk
  import rsPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       issueValid,
  input logic       robHasFree,
  input logic       issueAccept,
  input logic       flushValid,
  input logic       dispValid,
  input rsStrobes_t strobes,
  input slotVec_t   validVec,
  input slotVec_t   busyVec,
  input slotVec_t   readyVec
);
  p_accept_gated_r1: assert property (@(posedge clk) disable iff (!rstN)
    issueAccept |-> (issueValid && robHasFree && !flushValid));

  p_issue_into_empty_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.issueSel) |-> ((strobes.issueSel & validVec) == '0));

  p_one_dispatch_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.dispSel));

  p_dispatch_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.dispSel) |-> ((strobes.dispSel & ~(validVec & ~busyVec & readyVec)) == '0));

  p_freed_slot_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.freeSel) |=> ((validVec & $past(strobes.freeSel)) == '0));

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> !dispValid);
endmodule

bind rsPool rsPoolChk u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .robHasFree(robHasFree),
  .issueAccept(issueAccept), .flushValid(flushValid), .dispValid(dispValid),
  .strobes(strobes), .validVec(validVec), .busyVec(busyVec), .readyVec(readyVec)
);

// File: tb/sim_rsPool.sv
`timescale 1ns/1ps
module sim_rsPool;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 0, robHasFree = 0;
  logic [3:0]  issueOp = 0;
  logic        issueARdy = 0, issueBRdy = 0;
  logic [15:0] issueAData = 0, issueBData = 0;
  logic [2:0]  issueATag = 0, issueBTag = 0, issueDest = 0;
  logic        issueAccept, slotFree;
  logic        bcastValid = 0;
  logic [2:0]  bcastTag = 0;
  logic [15:0] bcastData = 0;
  logic        dispValid;
  logic [3:0]  dispOp;
  logic [15:0] dispA, dispB;
  logic [2:0]  dispDest;
  logic        flushValid = 0;
  logic [2:0]  flushTag = 0, robHead = 0;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rsPool #(.DATA_W(16), .TAG_W(3), .OP_W(4)) u0 (.*);

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    issueValid = 0; robHasFree = 0; issueOp = 0;
    issueARdy = 0; issueAData = 0; issueATag = 0;
    issueBRdy = 0; issueBData = 0; issueBTag = 0; issueDest = 0;
    bcastValid = 0; bcastTag = 0; bcastData = 0;
    flushValid = 0; flushTag = 0; robHead = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic offer(input logic [3:0] op, input logic aRdy, input logic [15:0] aVal,
                       input logic [2:0] aTag, input logic [15:0] bVal, input logic [2:0] dest);
    issueValid = 1; robHasFree = 1; issueOp = op;
    issueARdy = aRdy; issueAData = aVal; issueATag = aTag;
    issueBRdy = 1; issueBData = bVal; issueBTag = 0; issueDest = dest;
  endtask

  task automatic bcast(input logic [2:0] tag, input logic [15:0] val);
    bcastValid = 1; bcastTag = tag; bcastData = val;
  endtask

  task automatic expectDisp(string req, logic [3:0] op, logic [15:0] a, logic [15:0] b, logic [2:0] d);
    chk(req, "dispValid", int'(dispValid), 1);
    chk(req, "dispOp", int'(dispOp), int'(op));
    chk(req, "dispA", int'(dispA), int'(a));
    chk(req, "dispB", int'(dispB), int'(b));
    chk(req, "dispDest", int'(dispDest), int'(d));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    settle();
    // R2 reset state
    chk("R2", "slotFree after reset", int'(slotFree), 1);
    chk("R2", "dispValid after reset", int'(dispValid), 0);
    rstN = 1;

    // R1: no reorder-buffer entry -> rejected, nothing stored
    tick(); offer(4'h1, 1, 16'h0001, 0, 16'h0002, 3'd5); robHasFree = 0; settle();
    chk("R1", "accept without rob entry", int'(issueAccept), 0);
    tick(); settle();
    chk("R1", "nothing stored", int'(dispValid), 0);

    // R7 with slot reuse: youngest lands in slot 0
    tick(); offer(4'h5, 1, 16'h000A, 0, 16'h000B, 3'd4); settle();
    chk("R1", "accept ready op", int'(issueAccept), 1);
    tick(); offer(4'h6, 0, 16'h0, 3'd7, 16'h001B, 3'd1); settle();
    expectDisp("R3", 4'h5, 16'h000A, 16'h000B, 3'd4);
    tick(); offer(4'h7, 0, 16'h0, 3'd7, 16'h002B, 3'd2); settle();
    chk("R6", "dispatch once", int'(dispValid), 0);
    tick(); bcast(3'd4, 16'h9999); settle();
    tick(); offer(4'h8, 0, 16'h0, 3'd7, 16'h003B, 3'd3); settle();
    chk("R8", "accept into freed slot", int'(issueAccept), 1);
    tick(); bcast(3'd7, 16'h0077); settle();
    chk("R4", "no dispatch in wake cycle", int'(dispValid), 0);
    tick(); settle(); expectDisp("R7", 4'h6, 16'h0077, 16'h001B, 3'd1);
    tick(); settle(); expectDisp("R7", 4'h7, 16'h0077, 16'h002B, 3'd2);
    tick(); settle(); expectDisp("R7", 4'h8, 16'h0077, 16'h003B, 3'd3);
    tick(); settle(); chk("R6", "queue drained", int'(dispValid), 0);
    tick(); bcast(3'd1, 16'h0);
    tick(); bcast(3'd2, 16'h0);
    tick(); bcast(3'd3, 16'h0);

    // R5: broadcast during issue
    tick(); offer(4'h9, 0, 16'h0, 3'd6, 16'h000C, 3'd0); bcast(3'd6, 16'hABCD); settle();
    chk("R5", "accept", int'(issueAccept), 1);
    tick(); settle(); expectDisp("R5", 4'h9, 16'hABCD, 16'h000C, 3'd0);
    tick(); bcast(3'd0, 16'h0);
    // R8: destination broadcast before dispatch leaves slot in place
    tick(); offer(4'hA, 0, 16'h0, 3'd7, 16'h000D, 3'd2);
    tick(); bcast(3'd2, 16'h1111); settle();
    tick(); settle(); chk("R3", "pending source blocks dispatch", int'(dispValid), 0);
    bcast(3'd7, 16'h2222);
    tick(); settle(); expectDisp("R8", 4'hA, 16'h2222, 16'h000D, 3'd2);
    tick(); bcast(3'd2, 16'h0);

    // R9: flush with head 0
    for (int n = 1; n <= 4; n++) begin
      tick(); offer(4'(n), 0, 16'h0, 3'd7, 16'(n * 16), 3'(n)); settle();
      chk("R1", "fill for flush", int'(issueAccept), 1);
    end
    tick(); settle(); chk("R2", "full pool", int'(slotFree), 0);
    flushValid = 1; flushTag = 3'd2; robHead = 3'd0;
    tick(); settle(); chk("R9", "flush freed slots", int'(slotFree), 1);
    offer(4'h1, 1, 16'h1, 0, 16'h1, 3'd6); flushValid = 1; flushTag = 3'd5; settle();
    chk("R9", "issue blocked during flush", int'(issueAccept), 0);
    tick(); bcast(3'd7, 16'h0055);
    tick(); settle(); expectDisp("R9", 4'h1, 16'h0055, 16'h0010, 3'd1);
    tick(); settle(); expectDisp("R9", 4'h2, 16'h0055, 16'h0020, 3'd2);
    tick(); settle(); chk("R9", "younger entries gone", int'(dispValid), 0);
    bcast(3'd1, 16'h0);
    tick(); bcast(3'd2, 16'h0);

    // R9: wrapped tags, head 6
    tick(); offer(4'h3, 0, 16'h0, 3'd5, 16'h0007, 3'd7);
    tick(); offer(4'h4, 0, 16'h0, 3'd5, 16'h0008, 3'd0);
    tick(); offer(4'h5, 0, 16'h0, 3'd5, 16'h0009, 3'd1);
    tick(); flushValid = 1; flushTag = 3'd7; robHead = 3'd6;
    tick(); bcast(3'd5, 16'h0BEE);
    tick(); settle(); expectDisp("R9", 4'h3, 16'h0BEE, 16'h0007, 3'd7);
    tick(); settle(); chk("R9", "wrapped younger entries gone", int'(dispValid), 0);
    bcast(3'd7, 16'h0);

    // R9: flush suppresses dispatch for one cycle
    tick(); offer(4'h2, 1, 16'h0033, 0, 16'h0044, 3'd3);
    tick(); flushValid = 1; flushTag = 3'd4; settle();
    chk("R9", "dispatch held in flush cycle", int'(dispValid), 0);
    tick(); settle(); expectDisp("R9", 4'h2, 16'h0033, 16'h0044, 3'd3);
    tick(); bcast(3'd3, 16'h0);

    // R7 sweep: all four woken together dispatch in issue order
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 4; n++) begin
        tick(); offer(4'(n + k + 1), 0, 16'h0, 3'd7, 16'(256 * n + k), 3'((n + k) % 4)); settle();
        chk("R1", "sweep accept", int'(issueAccept), 1);
      end
      tick(); issueValid = 1; robHasFree = 1; settle();
      chk("R2", "slotFree when full", int'(slotFree), 0);
      chk("R1", "accept when full", int'(issueAccept), 0);
      chk("R3", "no dispatch while waiting", int'(dispValid), 0);
      tick(); bcast(3'd7, 16'(16'h0070 + k));
      for (int n = 0; n < 4; n++) begin
        tick(); settle();
        expectDisp("R7", 4'(n + k + 1), 16'(16'h0070 + k), 16'(256 * n + k), 3'((n + k) % 4));
      end
      tick(); settle(); chk("R6", "sweep drained", int'(dispValid), 0);
      bcast(3'((3 + k) % 4), 16'h0);
      tick(); settle(); chk("R8", "slot released", int'(slotFree), 1);
      for (int n = 0; n < 3; n++) begin
        bcast(3'((n + k) % 4), 16'h0);
        tick();
      end
    end

    finishRun();
  end
endmodule